// File: doc/BRIEF.md
# Exception-Bit Conditional Select Unit

This unit executes a family of four conditional-select instructions against a 32-entry, 64-bit general register file. A 4-bit condition index picks one of sixteen extended exception bits, numbered 32 through 47. When the chosen bit is 1, the first source goes to the destination register. When it is 0, the second source goes there instead. Each source is either a register or a 5-bit signed immediate, and the two-bit form field sets which.

The selected value appears combinationally on `sel_res` in the same cycle as the instruction. It is written to the destination register on the next clock edge when `valid` is high. An optional record bit loads a three-bit condition field that classifies the result as negative, positive or zero. A pairing often used in practice is the register/immediate form with an immediate of 0. It yields either a register value or zero, depending on a prior validity check that set the exception bit. Other execution units write into the same register file through a fill port.

Top module: `xsel_unit`

## Requirements
- R1: The form field encodes the operand kinds as 2'b00 immediate/immediate, 2'b01 immediate/register, 2'b10 register/immediate and 2'b11 register/register. Bit 1 clear makes the first source the immediate `fa`; bit 1 set makes it register `fa`. Bit 0 plays the same role for the second source and `fb`.
- R2: A 5-bit immediate is sign-extended to 64 bits. For example, 5'h10 gives -16 and 5'h0F gives +15.
- R3: Input `xbits[k]` holds exception bit 32+k. The condition is `xbits[xidx]`, so index 0 selects bit 32 and index 15 selects bit 47.
- R4: `sel_res` equals the first source when the condition bit is 1, and the second source when it is 0.
- R5: When `valid` is high, register `rt` receives `sel_res` at the next rising clock edge. When `valid` is low, no register changes.
- R6: The destination may equal a source. The source read in that cycle gives the value from before the write.
- R7: When `valid` and `rec` are both high, `cr` loads {negative, positive, zero} from the result at the next edge: 3'b100 for a negative result, 3'b010 for a positive one and 3'b001 for zero. In every other cycle `cr` holds its value.
- R8: After reset, every register reads 0 and `cr` is 3'b000.
- R9: When `fill_en` is high, register `fill_addr` takes `fill_data` at the next edge. If the select write-back targets the same register in the same cycle, the select write-back wins.
- R10: The register/immediate form with an immediate of 0 gives the register value when the condition bit is 1, and zero when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction present; enables write-back |
| form | input | 2 | Operand-form code |
| rt | input | 5 | Destination register |
| fa | input | 5 | First source: register number or immediate |
| fb | input | 5 | Second source: register number or immediate |
| xidx | input | 4 | Condition index into the exception bits |
| xbits | input | 16 | Exception bits 32..47 |
| rec | input | 1 | Record the condition field |
| fill_en | input | 1 | External register write enable |
| fill_addr | input | 5 | External register write address |
| fill_data | input | 64 | External register write data |
| sel_res | output | 64 | Selected result |
| cr | output | 3 | Condition field {neg, pos, zero} |

## Verification
The main function is tried with all four forms. Each form is run with the condition bit set and then clear, so that a swapped or mis-decoded source shows up as a wrong result. The immediates include the extremes -16 and +15 and a small negative value, which separates sign extension from zero extension. Some condition patterns set only the indexed bit, and others set every bit except it. These patterns catch an index off by one position or a fixed bit read in place of the indexed one. The register/immediate-zero pair, and cases where the destination equals a source, separate old-value reads from new-value reads and show the exact cycle of the write.

// File: rtl/xsel_unit.sv
module xsel_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [1:0]   form,
  input  logic [4:0]   rt,
  input  logic [4:0]   fa,
  input  logic [4:0]   fb,
  input  logic [3:0]   xidx,
  input  logic [15:0]  xbits,
  input  logic         rec,
  input  logic         fill_en,
  input  logic [4:0]   fill_addr,
  input  logic [W-1:0] fill_data,
  output logic [W-1:0] sel_res,
  output logic [2:0]   cr
);
  localparam int NREG = 32;
  localparam int IMMW = 5;

  logic [W-1:0] rf [NREG];
  logic [W-1:0] src_a, src_b;
  logic         cond;

  assign src_a   = form[1] ? rf[fa] : {{(W-IMMW){fa[IMMW-1]}}, fa};
  assign src_b   = form[0] ? rf[fb] : {{(W-IMMW){fb[IMMW-1]}}, fb};
  assign cond    = xbits[xidx];
  assign sel_res = cond ? src_a : src_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (fill_en) rf[fill_addr] <= fill_data;
      if (valid)   rf[rt] <= sel_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cr <= 3'b000;
    else if (valid && rec)
      cr <= {sel_res[W-1], !sel_res[W-1] && (sel_res != '0), sel_res == '0};
  end
endmodule

module xsel_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid,
  input logic [1:0]   form,
  input logic [4:0]   rt,
  input logic [4:0]   fa,
  input logic [3:0]   xidx,
  input logic [15:0]  xbits,
  input logic         rec,
  input logic [W-1:0] sel_res,
  input logic [2:0]   cr,
  input logic [W-1:0] rf [32]
);
  p_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> rf[$past(rt)] == $past(sel_res));
  p_imm_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (form == 2'b00 && xbits[xidx]) |-> sel_res == {{(W-5){fa[4]}}, fa});
  p_reg_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (form == 2'b11 && xbits[xidx]) |-> sel_res == rf[fa]);
  p_cr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rec) |=> $countones(cr) == 1);
  p_cr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rec && sel_res == '0) |=> cr == 3'b001);
  p_cr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && rec) |=> $stable(cr));
endmodule

bind xsel_unit xsel_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .form(form), .rt(rt), .fa(fa),
  .xidx(xidx), .xbits(xbits), .rec(rec), .sel_res(sel_res), .cr(cr), .rf(rf)
);

// File: tb/tb_xsel_unit.sv
module tb_xsel_unit;
  logic        clk = 0, rst_n = 0, valid = 0, rec = 0, fill_en = 0;
  logic [1:0]  form = 0;
  logic [4:0]  rt = 0, fa = 0, fb = 0, fill_addr = 0;
  logic [3:0]  xidx = 0;
  logic [15:0] xbits = 0;
  logic [63:0] fill_data = 0, sel_res;
  logic [2:0]  cr;
  int total = 0, bad = 0;
  bit done = 0;

  xsel_unit dut (.*);

  always #4 clk = ~clk;

  // form, fa, fb, xidx, xbits, expected
  localparam logic [95:0] VEC [9] = '{
    {2'b00, 5'h05, 5'h1D, 4'd0,  16'h0001, 64'h0000_0000_0000_0005},
    {2'b00, 5'h10, 5'h0F, 4'd0,  16'h0000, 64'h0000_0000_0000_000F},
    {2'b00, 5'h10, 5'h01, 4'd15, 16'h8000, 64'hFFFF_FFFF_FFFF_FFF0},
    {2'b01, 5'h1F, 5'd4,  4'd9,  16'h0200, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b01, 5'h1F, 5'd4,  4'd9,  16'hFDFF, 64'h0000_1000_0000_0004},
    {2'b10, 5'd3,  5'h00, 4'd9,  16'h0200, 64'hF000_0000_0000_0003},
    {2'b10, 5'd3,  5'h00, 4'd9,  16'hFDFF, 64'h0000_0000_0000_0000},
    {2'b11, 5'd7,  5'd10, 4'd5,  16'h0020, 64'hF000_0000_0000_0007},
    {2'b11, 5'd7,  5'd10, 4'd5,  16'hFFDF, 64'h0000_1000_0000_000A}
  };

  function automatic logic [63:0] regval(int i);
    return (i % 2 == 1) ? 64'hF000_0000_0000_0000 + 64'(i) : 64'h0000_1000_0000_0000 + 64'(i);
  endfunction

  function automatic logic [2:0] crof(logic [63:0] v);
    return v[63] ? 3'b100 : (v == 0 ? 3'b001 : 3'b010);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    valid = 0; fill_en = 0;
  endtask

  task automatic rd(int r, output logic [63:0] v);
    form = 2'b11; fa = 5'(r); fb = 5'(r); #1 v = sel_res;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [2:0]  crsave;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(5, v);  chk("R8 reg reset", v, 0);
    chk("R8 cr reset", 64'(cr), 0);

    for (int i = 0; i < 16; i++) begin
      fill_en = 1; fill_addr = 5'(i); fill_data = regval(i);
      step();
    end
    rd(11, v); chk("R9 fill", v, regval(11));

    for (int k = 0; k < 9; k++) begin
      {form, fa, fb, xidx, xbits} = VEC[k][95:64];
      rt = 5'(20 + k); valid = 1; rec = 1;
      #1 chk("R1 R2 R3 R4 R10 select", sel_res, VEC[k][63:0]);
      step();
      chk("R7 cr", 64'(cr), 64'(crof(VEC[k][63:0])));
      rd(20 + k, v); chk("R5 writeback", v, VEC[k][63:0]);
    end

    crsave = cr;
    form = 2'b00; fa = 5'd7; xidx = 0; xbits = 16'h0001; rt = 5'd30; rec = 1; valid = 0;
    step();
    rd(30, v); chk("R5 no write when idle", v, 0);
    chk("R7 cr hold idle", 64'(cr), 64'(crsave));

    form = 2'b00; fa = 5'h1D; xbits = 16'h0001; rt = 5'd31; rec = 0; valid = 1;
    step();
    rd(31, v); chk("R5 write rec off", v, 64'hFFFF_FFFF_FFFF_FFFD);
    chk("R7 cr hold rec off", 64'(cr), 64'(crsave));

    form = 2'b11; rt = 5'd11; fa = 5'd11; fb = 5'd12; xidx = 0; xbits = 16'h0001; valid = 1;
    #1 chk("R6 old value read", sel_res, regval(11));
    step();
    rd(11, v); chk("R6 self write", v, regval(11));
    form = 2'b11; rt = 5'd11; fa = 5'd11; fb = 5'd12; xbits = 16'h0000; valid = 1;
    #1 chk("R6 old value before overwrite", sel_res, regval(12));
    step();
    rd(11, v); chk("R6 overwrite", v, regval(12));

    fill_en = 1; fill_addr = 5'd13; fill_data = 64'hDEAD;
    form = 2'b00; fa = 5'd5; xidx = 0; xbits = 16'h0001; rt = 5'd13; valid = 1; rec = 0;
    step();
    rd(13, v); chk("R9 select wins", v, 5);
    fill_en = 1; fill_addr = 5'd14; fill_data = 64'hBEEF;
    form = 2'b00; fa = 5'd3; xbits = 16'h0001; rt = 5'd15; valid = 1;
    step();
    rd(14, v); chk("R9 fill alongside", v, 64'hBEEF);
    rd(15, v); chk("R9 select alongside", v, 3);

    form = 2'b11; fa = 5'd4; fb = 5'd3; xidx = 4'd14; xbits = 16'h8000;
    #1 chk("R3 adjacent bit clear", sel_res, regval(3));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule